// File: doc/BRIEF.md
# Narrow float to FP32 widener

The block widens a small floating-point value into an IEEE single-precision word. The value sits in the low bits of an 8-bit data input. A 3-bit format code chooses how those bits are read: as one of two 8-bit encodings, one of two 6-bit encodings, or a 4-bit encoding. The block splits the value into sign, exponent and mantissa, and classifies it as NaN, infinity, zero, subnormal or normal. It then writes the matching FP32 pattern. Every source value can be represented exactly in FP32, so the block does no rounding.

Each format has its own rule for special values. The 8-bit 5/2 format follows the IEEE rules. The 8-bit 4/3 format has a single NaN code point and no infinity. The 6-bit and 4-bit formats have finite values only. Subnormal inputs are normalized by locating their most significant mantissa bit. An input is accepted when its valid strobe is high, and the result appears one clock later in an output register. An error flag marks format codes that are not supported.

Top module: `narrow_fp_widen`

## Requirements
- R1: `fmt_i` selects the layout. Code 0 is 5-bit exponent / 2-bit mantissa, with the sign in bit 7. Code 1 is 4/3, sign in bit 7. Code 2 is 3/2, sign in bit 5. Code 3 is 2/3, sign in bit 5. Code 4 is 2/1, sign in bit 3. In every layout the mantissa occupies the lowest bits and the exponent sits directly above it. Data bits above the sign bit are ignored.
- R2: A normal input (nonzero exponent, not special) gives the FP32 exponent e + 127 − b, with b = 15, 7, 3, 1, 1 for codes 0 to 4. Its mantissa is left-aligned at the top of the 23-bit fraction. The sign is copied.
- R3: A subnormal input (exponent 0, mantissa nonzero) with top set mantissa bit at position p gives FP32 exponent p + 128 − b − mw, where mw is the mantissa width. The fraction holds the mantissa bits below p, left-aligned.
- R4: For code 0, an all-ones exponent with a zero mantissa gives a signed infinity (sign, 0xFF, zero fraction). An all-ones exponent with a nonzero mantissa is NaN.
- R5: For code 1, only the code with every exponent and mantissa bit set (low 7 bits 0x7F) is NaN. Any other all-ones exponent is a normal number, for example 0x7E gives 0x43E00000.
- R6: Codes 2, 3 and 4 never produce NaN or infinity. An all-ones exponent decodes as a normal number.
- R7: Every NaN input gives 0x7FC00000, whatever its sign.
- R8: A zero input keeps its sign: +0 gives 0x00000000 and −0 gives 0x80000000.
- R9: Codes 5, 6 and 7 give a result of 0 with `fmt_err_o` high. Supported codes give `fmt_err_o` low.
- R10: `out_valid_o` is high exactly one cycle after each cycle with `in_valid_i` high. When no input is accepted, `result_o` and `fmt_err_o` hold their values.
- R11: An active-low asynchronous reset clears `out_valid_o`, `fmt_err_o` and `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input accepted this cycle |
| fmt_i | input | 3 | Source format code |
| data_i | input | 8 | Packed narrow value, low-aligned |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | FP32 bit pattern |
| fmt_err_o | output | 1 | Unsupported format code seen |

## Verification
The assertions check the handshake timing and the hold of the outputs on every cycle. They also check that codes 5 to 7 always give the error flag with a zero result, and that any NaN output is the canonical pattern. They further check that the finite-only formats never reach an all-ones FP32 exponent, that the code 0 infinity and the code 1 NaN decode correctly, and that the sign is carried through for code 1. The exact exponent and fraction values of the normal and subnormal paths can only be shown by the bench scenarios. This covers the ignored high data bits, and reset mid-stream as well. The bench compares these values against a reference that uses integer normalization.

// File: rtl/nfw_pkg.sv
`timescale 1ns/1ps
package nfw_pkg;
  localparam int SRC_W     = 8;
  localparam int FMT_W     = 3;
  localparam int EXP_MAX_W = 5;
  localparam int MAN_MAX_W = 3;
  localparam int DST_EXP_W = 8;
  localparam int DST_MAN_W = 23;
  localparam int DST_W     = 1 + DST_EXP_W + DST_MAN_W;
  localparam int DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int MW_W      = $clog2(MAN_MAX_W + 1);
  localparam int BIAS_W    = EXP_MAX_W;

  typedef enum logic [FMT_W-1:0] {
    FMT_E5M2 = 3'd0,
    FMT_E4M3 = 3'd1,
    FMT_E3M2 = 3'd2,
    FMT_E2M3 = 3'd3,
    FMT_E2M1 = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    SPC_IEEE,
    SPC_NAN_ONLY,
    SPC_FINITE
  } spc_e;

  typedef struct packed {
    logic                 sign;
    logic [EXP_MAX_W-1:0] exp;
    logic [MAN_MAX_W-1:0] man;
    logic [MW_W-1:0]      mw;
    logic [BIAS_W-1:0]    bias;
    logic                 is_nan;
    logic                 is_inf;
    logic                 bad_fmt;
  } fld_t;

  localparam logic [DST_W-1:0] QNAN = {1'b0, {DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};
endpackage

// File: rtl/nfw_msb.sv
`timescale 1ns/1ps
module nfw_msb #(
  parameter int W  = 3,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
  end
endmodule

// File: rtl/nfw_unpack.sv
`timescale 1ns/1ps
module nfw_unpack
  import nfw_pkg::*;
(
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [SRC_W-1:0] data_i,
  output fld_t             fld_o
);
  logic [2:0]           ew;
  logic [MW_W-1:0]      mw;
  logic [BIAS_W-1:0]    bias;
  spc_e                 spc;
  logic                 bad;
  logic [SRC_W-1:0]     shifted;
  logic [EXP_MAX_W-1:0] emask;
  logic [MAN_MAX_W-1:0] mmask;
  logic [EXP_MAX_W-1:0] exp_f;
  logic [MAN_MAX_W-1:0] man_f;
  logic                 exp_ones;

  always_comb begin
    bad = 1'b0;
    unique case (fmt_i)
      FMT_E5M2: begin ew = 3'd5; mw = 2'd2; bias = 5'd15; spc = SPC_IEEE;     end
      FMT_E4M3: begin ew = 3'd4; mw = 2'd3; bias = 5'd7;  spc = SPC_NAN_ONLY; end
      FMT_E3M2: begin ew = 3'd3; mw = 2'd2; bias = 5'd3;  spc = SPC_FINITE;   end
      FMT_E2M3: begin ew = 3'd2; mw = 2'd3; bias = 5'd1;  spc = SPC_FINITE;   end
      FMT_E2M1: begin ew = 3'd2; mw = 2'd1; bias = 5'd1;  spc = SPC_FINITE;   end
      default:  begin ew = 3'd2; mw = 2'd1; bias = 5'd1;  spc = SPC_FINITE; bad = 1'b1; end
    endcase
  end

  always_comb begin
    emask    = EXP_MAX_W'((1 << ew) - 1);
    mmask    = MAN_MAX_W'((1 << mw) - 1);
    shifted  = data_i >> mw;
    exp_f    = shifted[EXP_MAX_W-1:0] & emask;
    man_f    = data_i[MAN_MAX_W-1:0] & mmask;
    exp_ones = (exp_f == emask);
  end

  always_comb begin
    fld_o.sign    = data_i[3'(ew) + 3'(mw)];
    fld_o.exp     = exp_f;
    fld_o.man     = man_f;
    fld_o.mw      = mw;
    fld_o.bias    = bias;
    fld_o.bad_fmt = bad;
    unique case (spc)
      SPC_IEEE: begin
        fld_o.is_nan = exp_ones && (man_f != '0);
        fld_o.is_inf = exp_ones && (man_f == '0);
      end
      SPC_NAN_ONLY: begin
        fld_o.is_nan = exp_ones && (man_f == mmask);
        fld_o.is_inf = 1'b0;
      end
      default: begin
        fld_o.is_nan = 1'b0;
        fld_o.is_inf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nfw_pack.sv
`timescale 1ns/1ps
module nfw_pack
  import nfw_pkg::*;
(
  input  fld_t             fld_i,
  output logic [DST_W-1:0] word_o
);
  localparam int PW = $clog2(MAN_MAX_W);
  localparam int XW = DST_EXP_W + 1;

  logic [PW-1:0]        msb_pos;
  logic                 is_zero, is_sub;
  logic [XW-1:0]        exp_norm, exp_sub;
  logic [DST_MAN_W-1:0] frac_norm, frac_sub;
  logic [MAN_MAX_W-1:0] man_strip;
  logic [DST_W-1:0]     fin_word;

  nfw_msb #(.W(MAN_MAX_W)) u_msb (
    .vec_i (fld_i.man),
    .pos_o (msb_pos)
  );

  always_comb begin
    is_zero   = (fld_i.exp == '0) && (fld_i.man == '0);
    is_sub    = (fld_i.exp == '0) && (fld_i.man != '0);
    exp_norm  = XW'(fld_i.exp) + XW'(DST_BIAS) - XW'(fld_i.bias);
    frac_norm = DST_MAN_W'(fld_i.man) << (5'(DST_MAN_W) - 5'(fld_i.mw));
    // value = 1.f * 2^(pos + 1 - bias - mw)
    exp_sub   = XW'(msb_pos) + XW'(DST_BIAS + 1) - XW'(fld_i.bias) - XW'(fld_i.mw);
    man_strip = fld_i.man & ~(MAN_MAX_W'(1) << msb_pos);
    frac_sub  = DST_MAN_W'(man_strip) << (5'(DST_MAN_W) - 5'(msb_pos));
    fin_word  = is_sub ? {fld_i.sign, exp_sub[DST_EXP_W-1:0], frac_sub}
                       : {fld_i.sign, exp_norm[DST_EXP_W-1:0], frac_norm};
  end

  always_comb begin
    if (fld_i.bad_fmt)     word_o = '0;
    else if (fld_i.is_nan) word_o = QNAN;
    else if (fld_i.is_inf) word_o = {fld_i.sign, {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
    else if (is_zero)      word_o = {fld_i.sign, {(DST_W-1){1'b0}}};
    else                   word_o = fin_word;
  end
endmodule

// File: rtl/narrow_fp_widen.sv
`timescale 1ns/1ps
module narrow_fp_widen
  import nfw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [SRC_W-1:0] data_i,
  output logic             out_valid_o,
  output logic [DST_W-1:0] result_o,
  output logic             fmt_err_o
);
  fld_t             fld;
  logic [DST_W-1:0] word;

  nfw_unpack u_unpack (
    .fmt_i  (fmt_i),
    .data_i (data_i),
    .fld_o  (fld)
  );

  nfw_pack u_pack (
    .fld_i  (fld),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      fmt_err_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= word;
        fmt_err_o <= fld.bad_fmt;
      end
    end
  end
endmodule

// File: rtl/nfw_checker.sv
`timescale 1ns/1ps
module nfw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [2:0]  fmt_i,
  input logic [7:0]  data_i,
  input logic        out_valid_o,
  input logic [31:0] result_o,
  input logic        fmt_err_o
);
  p_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(fmt_err_o)));
  p_bad_fmt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i > 3'd4) |=> (fmt_err_o && result_o == 32'h0));
  p_good_fmt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i <= 3'd4) |=> !fmt_err_o);
  p_inf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 3'd0 && data_i[6:0] == 7'h7C)
      |=> result_o == {$past(data_i[7]), 8'hFF, 23'h0});
  p_nan_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 3'd1 && data_i[6:0] == 7'h7F) |=> result_o == 32'h7FC00000);
  p_canon_nan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && result_o[30:23] == 8'hFF && result_o[22:0] != 23'h0)
      |-> result_o == 32'h7FC00000);
  p_finite_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i >= 3'd2 && fmt_i <= 3'd4) |=> result_o[30:23] != 8'hFF);
  p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 3'd1 && data_i[6:0] != 7'h7F) |=> result_o[31] == $past(data_i[7]));
endmodule

bind narrow_fp_widen nfw_checker u_chk (.*);

// File: tb/narrow_fp_widen_tb.sv
`timescale 1ns/1ps
module narrow_fp_widen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [2:0]  fmt = '0;
  logic [7:0]  data = '0;
  logic        ovld;
  logic [31:0] res;
  logic        err;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  narrow_fp_widen u_dut (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (vld), .fmt_i (fmt), .data_i (data),
    .out_valid_o (ovld), .result_o (res), .fmt_err_o (err)
  );

  // reference: integer significand M * 2^E, normalized by search
  function automatic logic [32:0] ref_conv(input logic [2:0] f, input logic [7:0] d);
    int ew, mw, b, s, e, m, M, E, pos, x;
    logic [22:0] frac;
    case (f)
      3'd0: begin ew = 5; mw = 2; b = 15; end
      3'd1: begin ew = 4; mw = 3; b = 7;  end
      3'd2: begin ew = 3; mw = 2; b = 3;  end
      3'd3: begin ew = 2; mw = 3; b = 1;  end
      3'd4: begin ew = 2; mw = 1; b = 1;  end
      default: return {1'b1, 32'h0};
    endcase
    s = int'(d[ew+mw]);
    e = (int'(d) >> mw) & ((1 << ew) - 1);
    m = int'(d) & ((1 << mw) - 1);
    if (f == 3'd0 && e == 31 && m != 0) return {1'b0, 32'h7FC00000};
    if (f == 3'd1 && e == 15 && m == 7) return {1'b0, 32'h7FC00000};
    if (f == 3'd0 && e == 31) return {1'b0, s[0], 8'hFF, 23'h0};
    if (e == 0 && m == 0) return {1'b0, s[0], 31'h0};
    if (e == 0) begin M = m; E = 1 - b - mw; end
    else begin M = m + (1 << mw); E = e - b - mw; end
    pos = 0;
    for (int i = 0; i < 8; i++) if ((M >> i) & 1) pos = i;
    x = E + pos + 127;
    frac = 23'((M - (1 << pos)) << (23 - pos));
    return {1'b0, s[0], x[7:0], frac};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] f, input logic [7:0] d);
    logic [32:0] r;
    r = ref_conv(f, d);
    @(negedge clk);
    fmt = f; data = d; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check({req, " result"}, res, r[31:0]);
    check({req, " err"}, {31'h0, err}, {31'h0, r[32]});
    check("R10 valid", {31'h0, ovld}, 32'h1);
  endtask

  task automatic lit(input string req, input logic [2:0] f, input logic [7:0] d,
                     input logic [31:0] exp_v);
    @(negedge clk);
    fmt = f; data = d; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check(req, res, exp_v);
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    #1;
    check("R11 reset valid", {31'h0, ovld}, 32'h0);
    check("R11 reset err", {31'h0, err}, 32'h0);
    check("R11 reset result", res, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    lit("R2 e5m2 one", 3'd0, 8'h3C, 32'h3F800000);
    lit("R2 e4m3 one", 3'd1, 8'h38, 32'h3F800000);
    lit("R5 e4m3 448", 3'd1, 8'h7E, 32'h43E00000);
    lit("R3 e4m3 min sub", 3'd1, 8'h01, 32'h3B000000);
    lit("R3 e2m1 half", 3'd4, 8'h01, 32'h3F000000);
    lit("R6 e2m1 -6", 3'd4, 8'h0F, 32'hC0C00000);
    lit("R6 e3m2 28", 3'd2, 8'h1F, 32'h41E00000);
    lit("R4 +inf", 3'd0, 8'h7C, 32'h7F800000);
    lit("R4 -inf", 3'd0, 8'hFC, 32'hFF800000);
    lit("R4 nan", 3'd0, 8'h7D, 32'h7FC00000);
    lit("R7 neg nan", 3'd0, 8'hFF, 32'h7FC00000);
    lit("R5 e4m3 nan", 3'd1, 8'hFF, 32'h7FC00000);
    lit("R8 neg zero", 3'd0, 8'h80, 32'h80000000);
    lit("R8 pos zero", 3'd2, 8'h00, 32'h00000000);
    lit("R1 e2m1 high bits ignored", 3'd4, 8'hF1, 32'h3F000000);
    lit("R1 e3m2 high bits ignored", 3'd2, 8'hC0, 32'h00000000);
    apply("R3 e2m3 sub", 3'd3, 8'h03);
    apply("R9 code 5", 3'd5, 8'h3C);
    check("R9 err flag", {31'h0, err}, 32'h1);
    apply("R9 code 7", 3'd7, 8'hFF);

    apply("R10 before idle", 3'd1, 8'h45);
    held = res;
    @(negedge clk);
    fmt = 3'd0; data = 8'h7D;
    @(negedge clk);
    check("R10 idle valid", {31'h0, ovld}, 32'h0);
    check("R10 idle hold", res, held);

    for (int i = 0; i < 2000; i++) begin
      apply("R1 random", 3'($urandom_range(0, 7)), 8'($urandom));
    end
    for (int f = 0; f < 5; f++) begin
      for (int d = 0; d < 256; d++) apply("R2 sweep", 3'(f), 8'(d));
    end

    apply("R11 pre", 3'd6, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 mid reset err", {31'h0, err}, 32'h0);
    check("R11 mid reset valid", {31'h0, ovld}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule